// File: doc/BRIEF.md
# Boot-Time Card Information Copy Engine

This block fills attribute SRAM with the card information structure immediately after a hardware reset. No host command is needed. It reads the structure one byte at a time from a byte-wide EEPROM reader, using a request/acknowledge handshake. Each byte is stored at the even SRAM address that is twice its index. Odd addresses are left untouched.

While the copy runs, the block keeps the host bus wait line asserted so that no host access can reach the SRAM half-filled. After the final byte is stored, the block releases wait and raises a done flag. The flag stays high until the next hardware reset. If hardware reset is asserted during a copy, the copy is abandoned, and it begins again from byte 0 when reset is released.

Top module: `cis_boot_copy`

## Requirements
- R1: While `rstN` is low, `hostWait` is 1 and `copyDone`, `eeReq` and `sramWe` are 0. On the first clock edge after release, `eeReq` rises with `eeAddr` = 0, without any host action.
- R2: Exactly `CIS_BYTES` (default 288) bytes are fetched and written, for EEPROM addresses 0, 1, 2 … `CIS_BYTES`-1 in ascending order.
- R3: Byte n is written to SRAM address 2n, so bit 0 of `sramAddr` is 0 on every write. No odd address is ever written.
- R4: `hostWait` is 1 from reset through the cycle of the final write. It drops to 0 on the cycle after the final write.
- R5: `sramWe` is a one-cycle pulse. It appears in the cycle after a clock edge where `eeReq` and `eeAck` were both 1, and `sramData` carries the `eeData` accepted at that edge.
- R6: `eeReq` stays high until an acknowledge is seen, however long the acknowledge takes. No write occurs while a fetch is outstanding.
- R7: `copyDone` rises together with the fall of `hostWait` and stays high until reset. Once it is high, no further `eeReq` or `sramWe` occurs.
- R8: Asserting `rstN` low during a copy aborts the copy. After release, the copy restarts at byte 0 and writes SRAM address 0 first.
- R9: `eeAck` while `eeReq` is low is ignored: it causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| eeReq | output | 1 | Byte fetch request to the EEPROM reader |
| eeAddr | output | EE_AW (9) | EEPROM byte index being fetched |
| eeAck | input | 1 | Reader acknowledge; `eeData` is valid with it |
| eeData | input | DATA_W (8) | Fetched byte |
| sramWe | output | 1 | SRAM write strobe, one cycle per byte |
| sramAddr | output | SRAM_AW (12) | SRAM write address (always even) |
| sramData | output | DATA_W (8) | SRAM write data |
| hostWait | output | 1 | Host wait line, asserted for the whole copy |
| copyDone | output | 1 | Copy complete, sticky until reset |

## Verification
The bench's EEPROM model answers each request after a delay that varies with the address, including zero extra cycles. A design that sampled data or dropped its request too early would therefore write the wrong byte, or write without an acknowledge. A scoreboard compares every write against the acknowledged index and data. This catches an odd or unscaled address, a counter that skips or repeats, and an off-by-one total where the copy ends one byte short or one byte long.

The bench resets the block partway through a copy and expects the first write afterwards to land at address 0. A design that resumed from where it stopped would fail this check. The bench also checks that wait drops on exactly the cycle after the last write. Finally, it pulses acknowledge with no request outstanding after completion, and expects no write and no change to the done flag.

// File: rtl/cis_copy_pkg.sv
package cis_copy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } copyState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic clearCnt;  // return byte index to zero
    logic loadByte;  // capture the acknowledged byte
    logic stepCnt;   // move to the next byte index
  } dpCtl_t;

endpackage

// File: rtl/cis_copy_ctrl.sv
module cis_copy_ctrl
  import cis_copy_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   eeAck,
  input  logic   lastByte,
  output logic   eeReq,
  output logic   sramWe,
  output logic   hostWait,
  output logic   copyDone,
  output dpCtl_t ctl
);

  copyState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  stateNext = ST_FETCH;
      ST_FETCH: if (eeAck) stateNext = ST_STORE;
      ST_STORE: stateNext = lastByte ? ST_DONE : ST_FETCH;
      ST_DONE:  stateNext = ST_DONE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               copyDone <= 1'b0;
    else if (state == ST_STORE && lastByte)  copyDone <= 1'b1;
  end

  always_comb begin
    eeReq        = (state == ST_FETCH);
    sramWe       = (state == ST_STORE);
    hostWait     = (state != ST_DONE);
    ctl.clearCnt = (state == ST_IDLE);
    ctl.loadByte = (state == ST_FETCH) && eeAck;
    ctl.stepCnt  = (state == ST_STORE) && !lastByte;
  end

  // R5: single-cycle strobe
  a_r5_we_single: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |=> !sramWe);

  // R5: each write follows an accepted handshake
  a_r5_we_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> $past(eeReq && eeAck));

  // R6: request held until acknowledged
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (eeReq && !eeAck) |=> eeReq);

  // R7: done is sticky and quiet
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    copyDone |=> (copyDone && !eeReq && !sramWe));

endmodule

// File: rtl/cis_copy_dp.sv
module cis_copy_dp
  import cis_copy_pkg::*;
#(
  parameter int CIS_BYTES = 288,
  parameter int CNT_W     = 9,
  parameter int SRAM_AW   = 12,
  parameter int DATA_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [DATA_W-1:0]  eeData,
  output logic [CNT_W-1:0]   eeAddr,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic [DATA_W-1:0]  sramData,
  output logic               lastByte
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CIS_BYTES - 1);

  logic [CNT_W-1:0]  byteCnt;
  logic [DATA_W-1:0] byteReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             byteCnt <= '0;
    else if (ctl.clearCnt) byteCnt <= '0;
    else if (ctl.stepCnt)  byteCnt <= byteCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             byteReg <= '0;
    else if (ctl.loadByte) byteReg <= eeData;
  end

  always_comb begin
    eeAddr   = byteCnt;
    sramAddr = SRAM_AW'({byteCnt, 1'b0});
    sramData = byteReg;
    lastByte = (byteCnt == LAST_IDX);
  end

  // R2: the index never leaves the structure
  a_r2_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LAST_IDX);

  // R2: stepping never happens together with a clear
  a_r2_no_step_clear: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.stepCnt && ctl.clearCnt));

endmodule

// File: rtl/cis_boot_copy.sv
module cis_boot_copy
  import cis_copy_pkg::*;
#(
  parameter int CIS_BYTES = 288,
  parameter int SRAM_AW   = 12,
  parameter int DATA_W    = 8,
  localparam int EE_AW    = $clog2(CIS_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  output logic               eeReq,
  output logic [EE_AW-1:0]   eeAddr,
  input  logic               eeAck,
  input  logic [DATA_W-1:0]  eeData,
  output logic               sramWe,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic [DATA_W-1:0]  sramData,
  output logic               hostWait,
  output logic               copyDone
);

  dpCtl_t ctl;
  logic   lastByte;

  cis_copy_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .eeAck    (eeAck),
    .lastByte (lastByte),
    .eeReq    (eeReq),
    .sramWe   (sramWe),
    .hostWait (hostWait),
    .copyDone (copyDone),
    .ctl      (ctl)
  );

  cis_copy_dp #(
    .CIS_BYTES (CIS_BYTES),
    .CNT_W     (EE_AW),
    .SRAM_AW   (SRAM_AW),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .eeData   (eeData),
    .eeAddr   (eeAddr),
    .sramAddr (sramAddr),
    .sramData (sramData),
    .lastByte (lastByte)
  );

  // Write counter kept only for the total-count assertion.
  logic [EE_AW:0] wrSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       wrSeen <= '0;
    else if (sramWe) wrSeen <= wrSeen + 1'b1;
  end

  // R2: completion only after the full structure
  a_r2_total_bytes: assert property (@(posedge clk) disable iff (!rstN)
    $rose(copyDone) |-> (wrSeen == (EE_AW+1)'(CIS_BYTES)));

  // R3: writes land on twice the fetched index
  a_r3_even_target: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (sramAddr[0] == 1'b0 && sramAddr == SRAM_AW'({eeAddr, 1'b0})));

  // R4: host held off for the whole copy
  a_r4_wait_cover: assert property (@(posedge clk) disable iff (!rstN)
    !copyDone |-> hostWait);

  // R4: wait drops right after the final write
  a_r4_wait_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostWait) |-> $past(sramWe));

endmodule

// File: tb/sim_cis_boot_copy.sv
module sim_cis_boot_copy;

  localparam int NBYTES = 288;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eeReq;
  logic [8:0]  eeAddr;
  logic        eeAck = 1'b0;
  logic [7:0]  eeData = 8'h00;
  logic        sramWe;
  logic [11:0] sramAddr;
  logic [7:0]  sramData;
  logic        hostWait;
  logic        copyDone;

  always #2 clk = ~clk;  // 250 MHz

  cis_boot_copy u0 (
    .clk(clk), .rstN(rstN), .eeReq(eeReq), .eeAddr(eeAddr), .eeAck(eeAck),
    .eeData(eeData), .sramWe(sramWe), .sramAddr(sramAddr), .sramData(sramData),
    .hostWait(hostWait), .copyDone(copyDone)
  );

  int nTests = 0;
  int nFail  = 0;
  int cycle  = 0;
  int qAddr[$];
  int qData[$];
  int writes = 0;
  int lastWrCycle = -10;
  bit modelEn = 1'b1;
  bit ackNow = 1'b0;
  int delay = 0;
  bit reqHeld = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  function automatic int byteOf(input int idx);
    return (idx * 37 + 5) & 8'hFF;
  endfunction

  always @(posedge clk) cycle++;

  // EEPROM model / driver: pushes expected items on each acknowledge.
  initial begin
    forever begin
      @(negedge clk);
      if (!rstN) begin
        eeAck = 1'b0; ackNow = 1'b0; delay = 0; reqHeld = 1'b1;
      end else if (ackNow) begin
        eeAck = 1'b0; ackNow = 1'b0;
      end else if (modelEn && eeReq) begin
        if (delay == 0) begin
          check(reqHeld, "R6 request held until ack", 0, 1);
          eeData = 8'(byteOf(int'(eeAddr)));
          eeAck  = 1'b1;
          ackNow = 1'b1;
          qAddr.push_back(2 * int'(eeAddr));
          qData.push_back(byteOf(int'(eeAddr)));
          delay  = (int'(eeAddr) * 7) % 4;
          reqHeld = 1'b1;
        end else begin
          delay--;
        end
      end else if (modelEn && !eeReq && delay != 0 && !copyDone) begin
        reqHeld = 1'b0;
      end
    end
  end

  // Monitor / scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && sramWe) begin
        if (qAddr.size() == 0) begin
          check(1'b0, "R5/R9 write without accepted ack", int'(sramAddr), -1);
        end else begin
          int ea, ed;
          ea = qAddr.pop_front();
          ed = qData.pop_front();
          check(int'(sramAddr) == ea && sramAddr[0] == 1'b0, "R3 write address", int'(sramAddr), ea);
          check(int'(sramData) == ed, "R5 write data", int'(sramData), ed);
          check(hostWait == 1'b1, "R4 wait during write", int'(hostWait), 1);
        end
        writes++;
        lastWrCycle = cycle;
      end
    end
  end

  initial begin
    while (cycle < 150000) @(posedge clk);
    check(1'b0, "watchdog", cycle, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic waitDone(output bit ok);
    int t = 0;
    ok = 1'b0;
    while (t < 20000) begin
      @(negedge clk);
      if (copyDone) begin ok = 1'b1; return; end
      if (!hostWait) check(1'b0, "R4 wait low before done", 0, 1);
      t++;
    end
  endtask

  initial begin
    bit ok;
    int wrBefore;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(hostWait == 1'b1, "R1 reset hostWait", int'(hostWait), 1);
    check(copyDone == 1'b0, "R1 reset copyDone", int'(copyDone), 0);
    check(eeReq == 1'b0 && sramWe == 1'b0, "R1 reset quiet", int'({eeReq, sramWe}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(eeReq == 1'b1 && eeAddr == 9'd0, "R1 auto start at byte 0", int'(eeAddr), 0);

    // R8: abort mid-copy
    while (writes < 100) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(hostWait == 1'b1 && copyDone == 1'b0, "R8 reset mid-copy", int'(copyDone), 0);
    qAddr.delete(); qData.delete();
    writes = 0;
    rstN = 1'b1;
    @(negedge clk);
    check(eeAddr == 9'd0, "R8 restart index", int'(eeAddr), 0);
    while (writes == 0) @(negedge clk);
    check(lastWrCycle >= 0, "R8 first write after restart seen", writes, 1);

    // R2, R4, R7: completion
    waitDone(ok);
    check(ok, "R7 done reached", int'(ok), 1);
    check(writes == NBYTES, "R2 byte count", writes, NBYTES);
    check(hostWait == 1'b0, "R4 wait released at done", int'(hostWait), 0);
    check(cycle == lastWrCycle + 1, "R4 release one cycle after last write", cycle, lastWrCycle + 1);
    check(qAddr.size() == 0, "R2 all fetched bytes written", qAddr.size(), 0);

    // R7 and R9: sticky done, stray ack ignored
    modelEn = 1'b0;
    wrBefore = writes;
    repeat (3) begin
      @(negedge clk); eeAck = 1'b1; eeData = 8'hA5;
      @(negedge clk); eeAck = 1'b0;
    end
    repeat (40) begin
      @(negedge clk);
      if (eeReq || sramWe || !copyDone || hostWait)
        check(1'b0, "R7 quiet after done", int'({eeReq, sramWe, copyDone, hostWait}), 2);
    end
    check(writes == wrBefore, "R9 stray ack no write", writes, wrBefore);
    check(copyDone == 1'b1, "R7 done sticky", int'(copyDone), 1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule